// File: doc/BRIEF.md
# Linear CCD readout timing generator

This block drives a two-output linear CCD line sensor from a fast system clock. It produces the complementary two-phase horizontal shift clocks, the output-node reset clock, two transfer-gate pulses and a vertical-transfer pulse. Every line opens with a transfer interval. During that interval the gates fire while the horizontal clocks are parked, and a readout interval of 1064 pixel periods follows. Lines run back to back for as long as reset is released.

Alongside the drive clocks, the block tags every pixel period on both sensor outputs. Channel 1 carries red and blue interleaved, and channel 2 carries green. Each tag marks the period as dummy, black reference or a valid colour, so that downstream sampling logic knows what each sample is. Two sequences exist. In the plain sequence both gates fire together. In the delayed-line sequence the first gate and the vertical pulse fire first and the second gate follows after a programmed gap.

All intervals are programmed as counts of system clock cycles and are clamped to the legal range. The block samples them once per line, on the first cycle of the line. Every drive output comes straight from a flip-flop.

Top module: `ccd_timing_gen`

## Requirements
- R1: While rst_n is low, hclk_p1 is 1, and hclk_p2, orst, xgate1, xgate2, vxfer, line_start and pix_strobe are 0. Both tags are 0 during reset.
- R2: hclk_p1 and hclk_p2 are never equal. In readout each pixel period lasts 2T cycles, with hclk_p1 high for the first T cycles and hclk_p2 high for the last T cycles.
- R3: orst is high for the first RST_W cycles of every pixel period and low at all other times. RST_W is ceil(CYC_PER_US/10), which is 1 at the default setting. orst is high only while hclk_p1 is high.
- R4: vxfer equals xgate1 on every cycle.
- R5: Plain sequence (cfg_delay_mode=0). xgate1 and xgate2 both rise on the first cycle of the line and stay high for GW cycles. Readout starts GS cycles after they fall.
- R6: Delayed-line sequence (cfg_delay_mode=1). xgate1 and vxfer are high for GW cycles. xgate2 rises VX cycles after they fall and stays high for GW cycles. Readout starts GS cycles after xgate2 falls. In both sequences, the transfer interval holds hclk_p1=1, hclk_p2=0 and orst=0.
- R7: pix_strobe is a one-cycle pulse on the first cycle of each of the 1064 pixel periods. The first pulse occurs on the first readout cycle.
- R8: Each tag is held for its whole period. Periods 0..31 are black (1) on both channels, periods 32..35 are dummy (0), and periods 1060..1063 are dummy (0). For the valid periods 36..1059, channel 2 carries green (2). Channel 1 carries red (2) at even valid index and blue (3) at odd valid index, with red first.
- R9: line_start is a one-cycle pulse on the cycle xgate1 rises. The next line starts on the cycle after the last pixel period ends, so a line lasts GW + (delay ? VX+GW : 0) + GS + 1064·2T cycles.
- R10: The programmed values are clamped, here with CYC_PER_US=8. T is clamped to 2..40, GW to 40..400, and GS and VX each to 4..16.
- R11: Configuration inputs are sampled only on the first cycle of a line. A change made mid-line takes effect from the next line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_half_period | input | W | Half pixel period T in clock cycles |
| cfg_gate_width | input | W | Transfer-gate pulse width GW in cycles |
| cfg_gate_setup | input | W | Gate-to-readout setup GS in cycles |
| cfg_vx_setup | input | W | Delayed-line gap VX between first and second gate |
| cfg_delay_mode | input | 1 | 1 selects the delayed-line gate sequence |
| hclk_p1 | output | 1 | Horizontal shift clock phase 1 |
| hclk_p2 | output | 1 | Horizontal shift clock phase 2 |
| orst | output | 1 | Output-node reset clock |
| xgate1 | output | 1 | First transfer-gate pulse |
| xgate2 | output | 1 | Second transfer-gate pulse |
| vxfer | output | 1 | Vertical-transfer pulse |
| line_start | output | 1 | One-cycle strobe at line start |
| pix_strobe | output | 1 | One-cycle strobe at each pixel period start |
| tag_ch1 | output | 2 | Red/blue channel tag |
| tag_ch2 | output | 2 | Green channel tag |

## Verification
The end of the last pixel period and the start of the next line fall on the same clock edge. On that edge the readout counters wrap, the configuration is re-sampled, the horizontal clocks are parked and xgate1 rises. The bench provokes this edge on every line by running lines back to back and rewriting every configuration input in the middle of each line. It switches between plain and delayed sequences and between clamped-low and clamped-high values. The bench judges the edge by the measured line length, by a gate-1 rise at offset zero, by gate widths that match the new line's sampled values, and by horizontal clocks that stay parked through the new transfer interval.

// File: rtl/ccd_tg_pkg.sv
package ccd_tg_pkg;

    typedef enum logic [2:0] {
        ST_BOOT   = 3'd0,
        ST_GATE_A = 3'd1,
        ST_GAP    = 3'd2,
        ST_GATE_B = 3'd3,
        ST_SETUP  = 3'd4,
        ST_READ   = 3'd5
    } seq_st_e;

    localparam logic [1:0] TAG_DUMMY = 2'd0;
    localparam logic [1:0] TAG_BLACK = 2'd1;
    localparam logic [1:0] TAG_COL_A = 2'd2;
    localparam logic [1:0] TAG_COL_B = 2'd3;

    // reset-pulse length in system cycles: at least 100 ns
    function automatic int rst_cycles(input int cyc_per_us);
        return (cyc_per_us + 9) / 10;
    endfunction

    // reset hold in system cycles: at least 125 ns
    function automatic int hold_cycles(input int cyc_per_us);
        return (cyc_per_us * 125 + 999) / 1000;
    endfunction

    function automatic logic [31:0] clip32(input logic [31:0] v,
                                           input logic [31:0] lo,
                                           input logic [31:0] hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

endpackage

// File: rtl/ccd_cfg_clamp.sv
module ccd_cfg_clamp #(
    parameter int CYC_PER_US = 8,
    parameter int W          = 16
) (
    input  logic [3:0][W-1:0] raw,
    output logic [3:0][W-1:0] clean
);
    import ccd_tg_pkg::*;

    localparam int T_RATE  = (CYC_PER_US + 5) / 6;
    localparam int T_RST   = rst_cycles(CYC_PER_US) + hold_cycles(CYC_PER_US);
    localparam int T_LO0   = (T_RATE > T_RST) ? T_RATE : T_RST;
    localparam int T_MIN   = (T_LO0 > 2) ? T_LO0 : 2;
    localparam int T_MAX   = CYC_PER_US * 5;
    localparam int GW_MIN  = CYC_PER_US * 5;
    localparam int GW_MAX  = CYC_PER_US * 50;
    localparam int SU_MIN  = (CYC_PER_US + 1) / 2;
    localparam int SU_MAX  = CYC_PER_US * 2;

    // field order: 0 half period, 1 gate width, 2 gate setup, 3 gap
    localparam int LO [4] = '{T_MIN, GW_MIN, SU_MIN, SU_MIN};
    localparam int HI [4] = '{T_MAX, GW_MAX, SU_MAX, SU_MAX};

    for (genvar i = 0; i < 4; i++) begin : g_fld
        assign clean[i] = W'(clip32(32'(raw[i]), LO[i], HI[i]));
    end

endmodule

// File: rtl/ccd_pixel_tagger.sv
module ccd_pixel_tagger #(
    parameter int N_BLACK = 32,
    parameter int N_PRE   = 4,
    parameter int N_VALID = 1024,
    parameter int WPIX    = 11
) (
    input  logic [WPIX-1:0] idx,
    output logic [1:0]      tag_ch1,
    output logic [1:0]      tag_ch2
);
    import ccd_tg_pkg::*;

    localparam logic [WPIX-1:0] B_END = WPIX'(N_BLACK);
    localparam logic [WPIX-1:0] V_LO  = WPIX'(N_BLACK + N_PRE);
    localparam logic [WPIX-1:0] V_HI  = WPIX'(N_BLACK + N_PRE + N_VALID);

    logic [WPIX-1:0] vidx;

    always_comb begin
        vidx    = idx - V_LO;
        tag_ch1 = TAG_DUMMY;
        tag_ch2 = TAG_DUMMY;
        if (idx < B_END) begin
            tag_ch1 = TAG_BLACK;
            tag_ch2 = TAG_BLACK;
        end else if (idx >= V_LO && idx < V_HI) begin
            tag_ch2 = TAG_COL_A;
            tag_ch1 = vidx[0] ? TAG_COL_B : TAG_COL_A;
        end
    end

endmodule

// File: rtl/ccd_line_seq.sv
module ccd_line_seq #(
    parameter int CYC_PER_US = 8,
    parameter int W          = 16,
    parameter int N_BLACK    = 32,
    parameter int N_PRE      = 4,
    parameter int N_VALID    = 1024,
    parameter int N_POST     = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] half_i,
    input  logic [W-1:0] gw_i,
    input  logic [W-1:0] gs_i,
    input  logic [W-1:0] vx_i,
    input  logic         dly_i,
    output logic         hp1_o,
    output logic         hp2_o,
    output logic         orst_o,
    output logic         sg1_o,
    output logic         sg2_o,
    output logic         vx_o,
    output logic         ls_o,
    output logic         ps_o,
    output logic [1:0]   tag1_o,
    output logic [1:0]   tag2_o
);
    import ccd_tg_pkg::*;

    localparam int NPIX  = N_BLACK + N_PRE + N_VALID + N_POST;
    localparam int WPIX  = $clog2(NPIX + 1);
    localparam int RST_W = rst_cycles(CYC_PER_US);

    typedef struct packed {
        seq_st_e         st;
        logic [W-1:0]    cnt;
        logic            half;
        logic [WPIX-1:0] pix;
        logic [W-1:0]    t;
        logic [W-1:0]    sgw;
        logic [W-1:0]    sgs;
        logic [W-1:0]    vxs;
        logic            dly;
        logic            hp1;
        logic            hp2;
        logic            orst;
        logic            sg1;
        logic            sg2;
        logic            vx;
        logic            ls;
        logic            ps;
        logic [1:0]      tag1;
        logic [1:0]      tag2;
    } seq_state_t;

    seq_state_t      q, d;
    logic            begin_line;
    logic [WPIX-1:0] tag_idx;
    logic [1:0]      nxt_t1, nxt_t2;

    assign tag_idx = (q.st == ST_READ) ? (q.pix + 1'b1) : '0;

    ccd_pixel_tagger #(
        .N_BLACK (N_BLACK),
        .N_PRE   (N_PRE),
        .N_VALID (N_VALID),
        .WPIX    (WPIX)
    ) u_tag (
        .idx     (tag_idx),
        .tag_ch1 (nxt_t1),
        .tag_ch2 (nxt_t2)
    );

    always_comb begin
        d          = q;
        d.ls       = 1'b0;
        d.ps       = 1'b0;
        begin_line = 1'b0;
        case (q.st)
            ST_GATE_A: begin
                if (q.cnt == q.sgw - 1'b1) begin
                    d.cnt = '0;
                    d.sg1 = 1'b0;
                    d.vx  = 1'b0;
                    if (q.dly) begin
                        d.st = ST_GAP;
                    end else begin
                        d.sg2 = 1'b0;
                        d.st  = ST_SETUP;
                    end
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_GAP: begin
                if (q.cnt == q.vxs - 1'b1) begin
                    d.cnt = '0;
                    d.sg2 = 1'b1;
                    d.st  = ST_GATE_B;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_GATE_B: begin
                if (q.cnt == q.sgw - 1'b1) begin
                    d.cnt = '0;
                    d.sg2 = 1'b0;
                    d.st  = ST_SETUP;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_SETUP: begin
                if (q.cnt == q.sgs - 1'b1) begin
                    d.st   = ST_READ;
                    d.cnt  = '0;
                    d.half = 1'b0;
                    d.pix  = '0;
                    d.ps   = 1'b1;
                    d.hp1  = 1'b1;
                    d.hp2  = 1'b0;
                    d.orst = 1'b1;
                    d.tag1 = nxt_t1;
                    d.tag2 = nxt_t2;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_READ: begin
                if (q.cnt == q.t - 1'b1) begin
                    d.cnt = '0;
                    if (!q.half) begin
                        d.half = 1'b1;
                        d.hp1  = 1'b0;
                        d.hp2  = 1'b1;
                        d.orst = 1'b0;
                    end else if (q.pix == WPIX'(NPIX - 1)) begin
                        begin_line = 1'b1;
                    end else begin
                        d.pix  = q.pix + 1'b1;
                        d.half = 1'b0;
                        d.hp1  = 1'b1;
                        d.hp2  = 1'b0;
                        d.orst = 1'b1;
                        d.ps   = 1'b1;
                        d.tag1 = nxt_t1;
                        d.tag2 = nxt_t2;
                    end
                end else begin
                    d.cnt = q.cnt + 1'b1;
                    if (!q.half && (q.cnt + 1'b1) == W'(RST_W)) d.orst = 1'b0;
                end
            end
            default: begin_line = 1'b1;
        endcase

        if (begin_line) begin
            d.st   = ST_GATE_A;
            d.cnt  = '0;
            d.half = 1'b0;
            d.pix  = '0;
            d.t    = half_i;
            d.sgw  = gw_i;
            d.sgs  = gs_i;
            d.vxs  = vx_i;
            d.dly  = dly_i;
            d.sg1  = 1'b1;
            d.vx   = 1'b1;
            d.sg2  = ~dly_i;
            d.ls   = 1'b1;
            d.hp1  = 1'b1;
            d.hp2  = 1'b0;
            d.orst = 1'b0;
            d.tag1 = TAG_DUMMY;
            d.tag2 = TAG_DUMMY;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.hp1 <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign hp1_o  = q.hp1;
    assign hp2_o  = q.hp2;
    assign orst_o = q.orst;
    assign sg1_o  = q.sg1;
    assign sg2_o  = q.sg2;
    assign vx_o   = q.vx;
    assign ls_o   = q.ls;
    assign ps_o   = q.ps;
    assign tag1_o = q.tag1;
    assign tag2_o = q.tag2;

endmodule

// File: rtl/ccd_timing_gen.sv
module ccd_timing_gen #(
    parameter int CYC_PER_US = 8,
    parameter int W          = 16,
    parameter int N_BLACK    = 32,
    parameter int N_PRE      = 4,
    parameter int N_VALID    = 1024,
    parameter int N_POST     = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cfg_half_period,
    input  logic [W-1:0] cfg_gate_width,
    input  logic [W-1:0] cfg_gate_setup,
    input  logic [W-1:0] cfg_vx_setup,
    input  logic         cfg_delay_mode,
    output logic         hclk_p1,
    output logic         hclk_p2,
    output logic         orst,
    output logic         xgate1,
    output logic         xgate2,
    output logic         vxfer,
    output logic         line_start,
    output logic         pix_strobe,
    output logic [1:0]   tag_ch1,
    output logic [1:0]   tag_ch2
);
    logic [3:0][W-1:0] cfg_raw, cfg_ok;

    assign cfg_raw = {cfg_vx_setup, cfg_gate_setup, cfg_gate_width, cfg_half_period};

    ccd_cfg_clamp #(
        .CYC_PER_US (CYC_PER_US),
        .W          (W)
    ) u_clamp (
        .raw   (cfg_raw),
        .clean (cfg_ok)
    );

    ccd_line_seq #(
        .CYC_PER_US (CYC_PER_US),
        .W          (W),
        .N_BLACK    (N_BLACK),
        .N_PRE      (N_PRE),
        .N_VALID    (N_VALID),
        .N_POST     (N_POST)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .half_i (cfg_ok[0]),
        .gw_i   (cfg_ok[1]),
        .gs_i   (cfg_ok[2]),
        .vx_i   (cfg_ok[3]),
        .dly_i  (cfg_delay_mode),
        .hp1_o  (hclk_p1),
        .hp2_o  (hclk_p2),
        .orst_o (orst),
        .sg1_o  (xgate1),
        .sg2_o  (xgate2),
        .vx_o   (vxfer),
        .ls_o   (line_start),
        .ps_o   (pix_strobe),
        .tag1_o (tag_ch1),
        .tag2_o (tag_ch2)
    );

endmodule

// File: rtl/ccd_timing_chk.sv
module ccd_timing_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       hclk_p1,
    input logic       hclk_p2,
    input logic       orst,
    input logic       xgate1,
    input logic       xgate2,
    input logic       vxfer,
    input logic       line_start,
    input logic       pix_strobe,
    input logic [1:0] tag_ch2
);
    // R2
    phase_comp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hclk_p1 != hclk_p2);

    // R3
    rst_in_p1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        orst |-> hclk_p1);

    // R4
    vx_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vxfer == xgate1);

    // R6
    park_in_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xgate1 || xgate2) |-> (hclk_p1 && !orst && !pix_strobe));

    // R7
    pix_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_strobe |=> !pix_strobe);

    // R9
    line_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> !line_start);

    // R9
    line_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |-> (xgate1 && !$past(xgate1)));

    // R8
    green_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tag_ch2 != 2'd3);
endmodule

bind ccd_timing_gen ccd_timing_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hclk_p1    (hclk_p1),
    .hclk_p2    (hclk_p2),
    .orst       (orst),
    .xgate1     (xgate1),
    .xgate2     (xgate2),
    .vxfer      (vxfer),
    .line_start (line_start),
    .pix_strobe (pix_strobe),
    .tag_ch2    (tag_ch2)
);

// File: tb/tb_ccd_timing_gen.sv
module tb_ccd_timing_gen;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 16;
    localparam int NPIX       = 1064;
    localparam int RSTW       = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0] c_half = '0, c_gw = '0, c_gs = '0, c_vx = '0;
    logic c_dly = 1'b0;
    logic hp1, hp2, orst, g1, g2, vx, ls, ps;
    logic [1:0] t1, t2;

    always #(CLK_PERIOD/2) clk = ~clk;

    ccd_timing_gen dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_half_period(c_half), .cfg_gate_width(c_gw), .cfg_gate_setup(c_gs),
        .cfg_vx_setup(c_vx), .cfg_delay_mode(c_dly),
        .hclk_p1(hp1), .hclk_p2(hp2), .orst(orst), .xgate1(g1), .xgate2(g2),
        .vxfer(vx), .line_start(ls), .pix_strobe(ps), .tag_ch1(t1), .tag_ch2(t2)
    );

    typedef struct {
        int kind; int off; int a; int b;
        int gw; int vxs; int su; int t; int dly; string lreq;
    } item_t;

    item_t sb[$];
    int total = 0, bad = 0, prev_len = 0, lines_seen = 0;
    bit prev_clamped = 1'b0, done = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int lim(input int v, input int lo, input int hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

    // driver: programs one line and pushes its expected events
    task automatic plan_line(input int tr, input int gr, input int sr,
                             input int vr, input int d, input bit clamped);
        item_t it;
        int rs;
        it.t   = lim(tr, 2, 40);     // R10 limits
        it.gw  = lim(gr, 40, 400);
        it.su  = lim(sr, 4, 16);
        it.vxs = lim(vr, 4, 16);
        it.dly = d;
        c_half = tr[W-1:0];
        c_gw   = gr[W-1:0];
        c_gs   = sr[W-1:0];
        c_vx   = vr[W-1:0];
        c_dly  = d[0];
        it.kind = 0;
        it.off  = prev_len;
        it.a    = 0;
        it.b    = 0;
        it.lreq = prev_clamped ? "R10" : "R9";
        sb.push_back(it);
        rs = it.gw + (d != 0 ? it.vxs + it.gw : 0) + it.su;
        for (int i = 0; i < NPIX; i++) begin
            it.kind = 1;
            it.off  = rs + i * 2 * it.t;
            if (i < 32) begin
                it.a = 1; it.b = 1;
            end else if (i >= 36 && i < 1060) begin
                it.b = 2;
                it.a = ((i - 36) % 2 == 1) ? 3 : 2;
            end else begin
                it.a = 0; it.b = 0;
            end
            sb.push_back(it);
        end
        prev_len     = rs + NPIX * 2 * it.t;
        prev_clamped = clamped;
    endtask

    // monitor state
    item_t cur, px;
    int since = 0;
    bit first = 1'b1;
    int g1r, g1f, g2r, g2f, rcount, p2count;
    bit p_g1 = 1'b0, p_g2 = 1'b0;
    bit comp_err, vx_err, hold_err, rph_err;

    task automatic evaluate();
        string gr;
        gr = (cur.dly != 0) ? "R6" : "R5";
        chk(g1r == 0, gr, "gate1 rise offset", g1r, 0);
        chk(g1f - g1r == cur.gw, gr, "gate1 width", g1f - g1r, cur.gw);
        chk(g2r == ((cur.dly != 0) ? cur.gw + cur.vxs : 0), gr, "gate2 rise offset",
            g2r, (cur.dly != 0) ? cur.gw + cur.vxs : 0);
        chk(g2f - g2r == cur.gw, gr, "gate2 width", g2f - g2r, cur.gw);
        chk(!vx_err, "R4", "vxfer differs from xgate1", int'(vx_err), 0);
        chk(!comp_err, "R2", "phases not complementary", int'(comp_err), 0);
        chk(!hold_err, "R6", "clocks not parked in transfer", int'(hold_err), 0);
        chk(!rph_err, "R3", "orst outside phase 1", int'(rph_err), 0);
        chk(rcount == NPIX * RSTW, "R3", "orst cycles per line", rcount, NPIX * RSTW);
        chk(p2count == NPIX * cur.t, "R11", "phase2 cycles per line", p2count, NPIX * cur.t);
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            since++;
            if (ls) begin
                if (!first) evaluate();
                if (sb.size() == 0) begin
                    chk(1'b0, "R9", "unexpected line start", 1, 0);
                end else begin
                    cur = sb.pop_front();
                    chk(cur.kind == 0, "R9", "line start order", cur.kind, 0);
                    if (!first) chk(cur.off == since, cur.lreq, "line length", since, cur.off);
                end
                first = 1'b0;
                since = 0;
                lines_seen++;
                comp_err = 0; vx_err = 0; hold_err = 0; rph_err = 0;
                rcount = 0; p2count = 0;
                g1r = -1; g1f = -1; g2r = -1; g2f = -1;
            end
            if (ps) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R7", "unexpected pixel strobe", 1, 0);
                end else begin
                    px = sb.pop_front();
                    chk(px.kind == 1 && px.off == since, "R7", "pixel strobe offset", since, px.off);
                    chk(int'(t1) == px.a, "R8", "channel 1 tag", int'(t1), px.a);
                    chk(int'(t2) == px.b, "R8", "channel 2 tag", int'(t2), px.b);
                end
            end
            if (!first) begin
                if (hp1 == hp2) comp_err = 1'b1;
                if (vx != g1) vx_err = 1'b1;
                if (orst) begin
                    rcount++;
                    if (!hp1) rph_err = 1'b1;
                end
                if (hp2) p2count++;
                if (since < cur.gw + ((cur.dly != 0) ? cur.vxs + cur.gw : 0) + cur.su)
                    if (!hp1 || hp2 || orst) hold_err = 1'b1;
                if (g1 && !p_g1) g1r = since;
                if (!g1 && p_g1) g1f = since;
                if (g2 && !p_g2) g2r = since;
                if (!g2 && p_g2) g2f = since;
            end
            p_g1 = g1;
            p_g2 = g2;
        end
    end

    task automatic wait_line();
        do @(negedge clk); while (!ls);
    endtask

    initial begin
        plan_line(4, 80, 8, 8, 0, 1'b0);           // line A: plain, defaults
        repeat (3) @(negedge clk);
        chk(hp1 == 1'b1, "R1", "hclk_p1 in reset", int'(hp1), 1);
        chk({hp2, orst, g1, g2, vx} == 5'b0, "R1", "drives in reset",
            int'({hp2, orst, g1, g2, vx}), 0);
        chk({ls, ps, t1, t2} == 6'b0, "R1", "strobes and tags in reset",
            int'({ls, ps, t1, t2}), 0);
        rst_n = 1'b1;
        wait_line();
        plan_line(2, 40, 16, 4, 1, 1'b0);          // line B: delayed, fastest legal
        wait_line();
        plan_line(1, 1, 100, 0, 1, 1'b1);          // line C: clamp low / high
        wait_line();
        plan_line(999, 1000, 3, 999, 0, 1'b1);     // line D: clamp the other way
        wait_line();
        plan_line(4, 80, 8, 8, 0, 1'b0);           // line E
        wait_line();
        @(negedge clk);
        chk(lines_seen == 5, "R9", "lines started", lines_seen, 5);
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            chk(1'b0, "R9", "watchdog expired", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule